// File: doc/BRIEF.md
# Microcoded Instruction Step Sequencer

This block sequences a small 8-bit microcoded processor core. Once an opcode byte has been fetched, the sequencer looks that byte up in a microcode table. Each opcode's entry in the table is padded to a fixed length of ten steps. The block then executes one micro-step on every clock. A step does two things. It applies one internal transition to the machine state, which is the value buffer, the address buffer, the register pair and the zero flag. It also places at most one memory request on the bus at the end of the step. That request is either a read or a write, never both, because the memory is a single-port synchronous RAM.

A read issued at the end of a step returns its byte on the data-in bus during the following step. A step that needs memory data therefore has its read issued by the step before it. The address pins are driven from one of two sources. The first is the address buffer, used for indirect access to the byte the register pair points at. The second is the program counter, which is used for opcode and operand fetches and always advances by one.

Every unused step slot holds the fetch-next micro-op. That micro-op reads the next opcode through the program counter and starts the following instruction at step 0.

Top module: `useq_core`

## Requirements
- R1: While reset is low, the write request, the zero flag and the halted output are all 0. In the first cycle after reset is released, the block requests a read at address 0x0000.
- R2: An opcode fetch is a read request at the program counter. The counter then advances by one. The data-in value in the next cycle is taken as the opcode, and that cycle is step 0 of its microcode.
- R3: Opcode 0x34 (increment memory) takes five cycles. Step 0 reads at the register pair. Steps 1 and 2 make no request. Step 3 writes the fetched byte plus one (modulo 256) to the register-pair address. Step 4 fetches the next opcode.
- R4: Opcode 0x35 (decrement memory) follows the R3 pattern, except that step 3 writes the fetched byte minus one (modulo 256).
- R5: Opcode 0x21 (load pair) reads two operand bytes at successive program-counter addresses and then fetches. The register pair becomes {second byte, first byte}.
- R6: Opcode 0x36 (store immediate) reads one operand byte at the program counter. It then writes that byte to the register-pair address, and then fetches. After any write, the next cycle is a fetch read.
- R7: Opcodes 0x34 and 0x35 set the zero flag to (result == 0x00) at the end of step 3, so the new value is visible from step 4. The flag changes at no other time.
- R8: Opcode 0x00, and every opcode not named in R3 to R6 or R9, takes one cycle. That cycle is a fetch, with no write and no change to the zero flag.
- R9: Opcode 0x76 (halt) makes no request in its step 0. The halted output rises in the next cycle and then stays high, and no further read or write is requested.
- R10: The read request and the write request are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | RAM address for the request made at the end of this cycle |
| mem_wdata | output | 8 | Write data (value buffer as this step leaves it) |
| mem_we | output | 1 | Write request at the end of this cycle |
| mem_re | output | 1 | Read request at the end of this cycle |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the read request |
| zero_flag | output | 1 | Zero flag |
| halted | output | 1 | High once a halt opcode has executed |

## Verification
A single program is run against a behavioural model, and the bus is compared on every cycle. The program exercises wrap-around in both directions: an increment of 0xFF gives 0x00 with the zero flag set, and a decrement of 0x00 gives 0xFF with the flag cleared. An increment from 0x00 to 0x01 clears the flag. Together these separate a flag computed from the result from one computed from the operand or the previous value.

Load-pair and store-immediate steps place operand reads and writes back to back, which exposes any off-by-one in the program-counter source or the write data. A NOP followed by an unassigned opcode checks the single-cycle fetch path. The final halt checks that the bus goes quiet and stays quiet.

// File: rtl/useq_core.sv
`timescale 1ns/1ps
module useq_core #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int N_STEPS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          zero_flag,
  output logic          halted
);
  localparam int SW = $clog2(N_STEPS);
  localparam logic [SW-1:0] LAST_STEP = SW'(N_STEPS - 1);

  localparam logic [DW-1:0] OP_LDPAIR = 8'h21;
  localparam logic [DW-1:0] OP_INCM   = 8'h34;
  localparam logic [DW-1:0] OP_DECM   = 8'h35;
  localparam logic [DW-1:0] OP_STIMM  = 8'h36;
  localparam logic [DW-1:0] OP_HALT   = 8'h76;

  typedef enum logic [3:0] {
    U_NONE, U_AB_PAIR, U_VB_LOAD, U_VB_INC, U_VB_DEC,
    U_FLAGS, U_LO_LOAD, U_HI_LOAD, U_HALT
  } uop_e;

  typedef enum logic [2:0] {
    Q_NONE, Q_RD_PC, Q_RD_AB, Q_WR_AB, Q_FETCH
  } req_e;

  typedef struct packed {
    uop_e uop;
    req_e req;
  } ustep_t;

  function automatic ustep_t ucode(input logic [DW-1:0] op, input logic [SW-1:0] st);
    ustep_t s;
    s = '{uop: U_NONE, req: Q_FETCH};
    case (op)
      OP_INCM, OP_DECM: begin
        case (st)
          SW'(0): s = '{uop: U_AB_PAIR, req: Q_RD_AB};
          SW'(1): s = '{uop: U_VB_LOAD, req: Q_NONE};
          SW'(2): s = '{uop: (op == OP_INCM) ? U_VB_INC : U_VB_DEC, req: Q_NONE};
          SW'(3): s = '{uop: U_FLAGS,   req: Q_WR_AB};
          default: ;
        endcase
      end
      OP_LDPAIR: begin
        case (st)
          SW'(0): s = '{uop: U_NONE,    req: Q_RD_PC};
          SW'(1): s = '{uop: U_LO_LOAD, req: Q_RD_PC};
          SW'(2): s = '{uop: U_HI_LOAD, req: Q_FETCH};
          default: ;
        endcase
      end
      OP_STIMM: begin
        case (st)
          SW'(0): s = '{uop: U_AB_PAIR, req: Q_RD_PC};
          SW'(1): s = '{uop: U_VB_LOAD, req: Q_WR_AB};
          default: ;
        endcase
      end
      OP_HALT: if (st == SW'(0)) s = '{uop: U_HALT, req: Q_NONE};
      default: ;
    endcase
    return s;
  endfunction

  logic [AW-1:0] pc, pair, ab, ab_d;
  logic [DW-1:0] vb, vb_d, ir, op_now;
  logic [SW-1:0] step;
  logic          new_op, booted, halt_q, zf;
  ustep_t        cur;

  assign op_now = new_op ? mem_rdata : ir;

  always_comb begin
    if (!booted)     cur = '{uop: U_NONE, req: Q_FETCH};
    else if (halt_q) cur = '{uop: U_NONE, req: Q_NONE};
    else             cur = ucode(op_now, step);
  end

  assign ab_d = (cur.uop == U_AB_PAIR) ? pair : ab;

  always_comb begin
    case (cur.uop)
      U_VB_LOAD: vb_d = mem_rdata;
      U_VB_INC:  vb_d = vb + 1'b1;
      U_VB_DEC:  vb_d = vb - 1'b1;
      default:   vb_d = vb;
    endcase
  end

  assign mem_re    = (cur.req == Q_RD_PC) || (cur.req == Q_RD_AB) || (cur.req == Q_FETCH);
  assign mem_we    = (cur.req == Q_WR_AB);
  assign mem_addr  = ((cur.req == Q_RD_AB) || (cur.req == Q_WR_AB)) ? ab_d : pc;
  assign mem_wdata = vb_d;
  assign zero_flag = zf;
  assign halted    = halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      pair   <= '0;
      ab     <= '0;
      vb     <= '0;
      ir     <= '0;
      step   <= '0;
      new_op <= 1'b0;
      booted <= 1'b0;
      halt_q <= 1'b0;
      zf     <= 1'b0;
    end else begin
      booted <= 1'b1;
      ab     <= ab_d;
      vb     <= vb_d;
      if (new_op) ir <= mem_rdata;
      if ((cur.req == Q_RD_PC) || (cur.req == Q_FETCH)) pc <= pc + 1'b1;
      if (cur.uop == U_LO_LOAD) pair[DW-1:0]  <= mem_rdata;
      if (cur.uop == U_HI_LOAD) pair[AW-1:DW] <= mem_rdata;
      if (cur.uop == U_FLAGS)   zf <= (vb == '0);
      if (cur.uop == U_HALT)    halt_q <= 1'b1;
      new_op <= (cur.req == Q_FETCH);
      if (cur.req == Q_FETCH)       step <= '0;
      else if (cur.uop == U_HALT)   step <= step;
      else if (step != LAST_STEP)   step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/useq_core_chk.sv
`timescale 1ns/1ps
module useq_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          zero_flag,
  input logic          halted
);
  p_boot_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mem_re && !mem_we && mem_addr == '0));

  p_fetch_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_re && !mem_we));

  p_zero_moves_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zero_flag) |-> $past(mem_we));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

  p_halt_entry_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(!mem_re && !mem_we));
endmodule

bind useq_core useq_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .zero_flag(zero_flag), .halted(halted)
);

// File: tb/useq_core_bench.sv
`timescale 1ns/1ps
module useq_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_re, zero_flag, halted;

  always #2 clk = ~clk;

  useq_core u_useq_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .zero_flag(zero_flag), .halted(halted)
  );

  logic [7:0] ram  [0:255];
  logic [7:0] mref [0:255];

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
  end

  int n_chk = 0;
  int n_bad = 0;

  logic [27:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mpc, mhl;
  logic        mz, mh;

  task automatic check(input logic ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic r, input logic w, input logic [15:0] a,
                      input logic [7:0] d, input string t);
    exp_q.push_back({r, w, a, d, mz, mh});
    tag_q.push_back(t);
  endtask

  task automatic expand();
    logic [7:0] op, lo, hi, v, nv;
    string t;
    if (mh) begin
      push(0, 0, 16'h0, 8'h0, "R9");
      return;
    end
    op = mref[mpc[7:0]];
    mpc = mpc + 1;
    case (op)
      8'h21: begin
        lo = mref[mpc[7:0]]; push(1, 0, mpc, 8'h0, "R5"); mpc = mpc + 1;
        hi = mref[mpc[7:0]]; push(1, 0, mpc, 8'h0, "R5"); mpc = mpc + 1;
        mhl = {hi, lo};
        push(1, 0, mpc, 8'h0, "R2");
      end
      8'h34, 8'h35: begin
        t  = (op == 8'h34) ? "R3" : "R4";
        v  = mref[mhl[7:0]];
        nv = (op == 8'h34) ? v + 8'd1 : v - 8'd1;
        push(1, 0, mhl, 8'h0, t);
        push(0, 0, 16'h0, 8'h0, t);
        push(0, 0, 16'h0, 8'h0, t);
        push(0, 1, mhl, nv, t);
        mref[mhl[7:0]] = nv;
        mz = (nv == 8'h00);
        push(1, 0, mpc, 8'h0, "R7");
      end
      8'h36: begin
        v = mref[mpc[7:0]];
        push(1, 0, mpc, 8'h0, "R6"); mpc = mpc + 1;
        push(0, 1, mhl, v, "R6");
        mref[mhl[7:0]] = v;
        push(1, 0, mpc, 8'h0, "R6");
      end
      8'h76: begin
        push(0, 0, 16'h0, 8'h0, "R9");
        mh = 1'b1;
      end
      default: push(1, 0, mpc, 8'h0, "R8");
    endcase
  endtask

  localparam int PLEN = 20;
  localparam logic [7:0] PROG [0:PLEN-1] = '{
    8'h21, 8'h40, 8'h00,  // load pair 0x0040
    8'h34,                // 0xFF -> 0x00, Z=1
    8'h34,                // 0x00 -> 0x01, Z=0
    8'h35,                // 0x01 -> 0x00, Z=1
    8'h00,                // nop
    8'h35,                // 0x00 -> 0xFF, Z=0
    8'hAA,                // unassigned
    8'h21, 8'h41, 8'h00,  // load pair 0x0041
    8'h34,                // 0x7F -> 0x80
    8'h36, 8'hFF,         // store 0xFF
    8'h21, 8'h40, 8'h00,  // load pair 0x0040
    8'h34,                // 0xFF -> 0x00, Z=1
    8'h76                 // halt
  };

  initial begin
    logic [27:0] e;
    string t;
    int halt_cycles;
    bit done;
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; mref[i] = 8'h00; end
    for (int i = 0; i < PLEN; i++) begin ram[i] = PROG[i]; mref[i] = PROG[i]; end
    ram[8'h40] = 8'hFF; mref[8'h40] = 8'hFF;
    ram[8'h41] = 8'h7F; mref[8'h41] = 8'h7F;
    mpc = 16'h0; mhl = 16'h0; mz = 1'b0; mh = 1'b0;

    repeat (3) @(negedge clk);
    check(mem_we == 1'b0, "R1", "we in reset", int'(mem_we), 0);
    check(zero_flag == 1'b0, "R1", "zero in reset", int'(zero_flag), 0);
    check(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    push(1, 0, 16'h0000, 8'h0, "R1");
    halt_cycles = 0;
    done = 0;
    for (int cyc = 0; cyc < 2000 && !done; cyc++) begin
      @(negedge clk);
      if (exp_q.size() == 0) expand();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(mem_re == e[27], t, "re", int'(mem_re), int'(e[27]));
      check(mem_we == e[26], t, "we", int'(mem_we), int'(e[26]));
      if (e[27] || e[26])
        check(mem_addr == e[25:10], t, "addr", int'(mem_addr), int'(e[25:10]));
      if (e[26])
        check(mem_wdata == e[9:2], t, "wdata", int'(mem_wdata), int'(e[9:2]));
      check(zero_flag == e[1], "R7", "zero", int'(zero_flag), int'(e[1]));
      check(halted == e[0], "R9", "halted", int'(halted), int'(e[0]));
      check(!(mem_re && mem_we), "R10", "re&we", int'(mem_re && mem_we), 0);
      if (e[0]) halt_cycles++;
      if (halt_cycles >= 8) done = 1;
    end
    if (!done) check(1'b0, "R9", "watchdog expired", 0, 1);

    check(ram[8'h40] == 8'h00, "R3", "final byte 0x40", int'(ram[8'h40]), 0);
    check(ram[8'h41] == 8'hFF, "R6", "final byte 0x41", int'(ram[8'h41]), 8'hFF);
    check(zero_flag == 1'b1, "R7", "final zero", int'(zero_flag), 1);
    check(halted == 1'b1, "R9", "final halted", int'(halted), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule